// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides whether an incoming frame should be kept, based only on its 48-bit destination address. The six address bytes arrive one per cycle. The first byte carries a start strobe. Once all six are held, the block runs a bit-serial CRC-32 over them, one bit per clock. The top six bits of the result form an index into a 64-bit multicast filter. Software reads and writes that filter as two 32-bit words.

The final verdict has four sources, and each one is switched by its own configuration bit. The first is an exact match against a station address. The second is the all-ones broadcast address. The third is a multicast address whose filter bit is set. The fourth is a mode that accepts everything. The verdict and the flags naming the matching source appear for exactly one cycle, together with a done strobe.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `done`, `accept` and all three hit flags are low, and both filter words read back as zero.
- R2: A byte is captured when `addr_valid` is high. A byte presented with `addr_start` becomes byte 0, even in the middle of a partly collected address. Bytes presented with no collection open are ignored. Byte k sits at address bits 8k+7..8k, and bit 0 of byte 0 is the first bit on the wire.
- R3: `done` is a one-cycle pulse. It is visible in the cycle after the 48th clock edge that follows the edge capturing byte 5. Bytes and strobes presented while the hash runs do not change the result.
- R4: The hash index is bits 31:26 of a CRC register. The register is preset to all ones and fed address bits 0 to 47 in order. For each bit, feedback = CRC bit 31 XOR the data bit. The register shifts left and, when feedback is 1, is XORed with 0x04C11DB7. No final inversion is applied.
- R5: Filter index 0 to 31 tests bit `index` of word 0 (`reg_sel`=0). Index 32 to 63 tests bit `index-32` of word 1. A write with `reg_wr` stores `reg_wdata` into the selected word. `reg_rdata` shows the selected word from the next cycle.
- R6: `hit_mcast` is set when all four of these hold: address bit 0 is 1, the address is not broadcast, `cfg_mode[2]` is 1, and the indexed filter bit is 1. With an all-zero filter, no multicast address is accepted through the hash.
- R7: An all-ones address gives `hit_bcast` when `cfg_mode[3]` is 1. It never gives `hit_mcast`, whatever the filter holds.
- R8: `hit_phys` is set when the address equals `station_addr` bit for bit and `cfg_mode[1]` is 1.
- R9: With `cfg_mode[0]` set, every completed address is accepted.
- R10: `accept` is the OR of `cfg_mode[0]` and the three hit flags. All four outputs are low whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_valid | input | 1 | Address byte present this cycle |
| addr_start | input | 1 | Marks the present byte as byte 0 |
| addr_byte | input | 8 | Address byte |
| cfg_mode | input | 4 | Enables: bit0 all, bit1 station, bit2 multicast, bit3 broadcast |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| reg_wr | input | 1 | Filter word write strobe |
| reg_sel | input | 1 | Filter word select (0 low, 1 high) |
| reg_wdata | input | 32 | Filter write data |
| reg_rdata | output | 32 | Selected filter word |
| done | output | 1 | Verdict valid strobe |
| accept | output | 1 | Address accepted |
| hit_phys | output | 1 | Station address match |
| hit_bcast | output | 1 | Broadcast match |
| hit_mcast | output | 1 | Multicast filter match |

## Verification
On every cycle, the assertions check four things: `done` never lasts two cycles, the outputs stay quiet without `done`, each hit flag implies `accept` and its own enable bit, and a filter write is seen on read-back. Some behaviour can only be shown by the bench scenarios, because it depends on the whole six-byte history: the exact hash index, the choice of filter word, the latency, the restart on a second start strobe, and the immunity to traffic during hashing.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int DAF_BYTE_W   = 8;
  localparam int DAF_N_BYTES  = 6;
  localparam int DAF_CRC_W    = 32;
  localparam logic [DAF_CRC_W-1:0] DAF_CRC_POLY = 32'h04C1_1DB7;
  localparam int CFG_ALL   = 0;
  localparam int CFG_PHYS  = 1;
  localparam int CFG_MCAST = 2;
  localparam int CFG_BCAST = 3;
  localparam int CFG_W     = 4;
endpackage

// File: rtl/daf_addr_capture.sv
module daf_addr_capture #(
  parameter int N_BYTES = 6,
  parameter int BYTE_W  = 8,
  localparam int ADDR_W = N_BYTES * BYTE_W,
  localparam int CNT_W  = $clog2(N_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [ADDR_W-1:0] addr,
  output logic              full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             take_first, take_next, last;

  assign take_first = in_valid & in_start & ~hold;
  assign take_next  = in_valid & ~in_start & open_q & ~hold;
  assign last       = take_next && (cnt_q == CNT_W'(N_BYTES - 1));
  assign full       = last;

  always_comb begin
    cnt_d  = cnt_q;
    open_d = open_q;
    if (take_first) begin
      cnt_d  = CNT_W'(1);
      open_d = 1'b1;
    end else if (take_next) begin
      if (last) begin
        cnt_d  = '0;
        open_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      open_q <= open_d;
    end
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    logic we;
    assign we = take_first ? (g == 0) : (take_next && (cnt_q == CNT_W'(g)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  addr[g*BYTE_W +: BYTE_W] <= '0;
      else if (we) addr[g*BYTE_W +: BYTE_W] <= in_byte;
    end
  end
endmodule

// File: rtl/daf_crc_serial.sv
module daf_crc_serial #(
  parameter int                 ADDR_W = 48,
  parameter int                 CRC_W  = 32,
  parameter int                 IDX_W  = 6,
  parameter logic [CRC_W-1:0]   POLY   = 32'h04C1_1DB7,
  localparam int                CNT_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] bits,
  output logic              busy,
  output logic              fin,
  output logic [IDX_W-1:0]  idx
);
  logic [CRC_W-1:0] crc_q, crc_d, step;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             fb;

  assign fb   = crc_q[CRC_W-1] ^ bits[cnt_q];
  assign step = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  assign fin  = busy_q && (cnt_q == CNT_W'(ADDR_W - 1));
  assign busy = busy_q;
  assign idx  = crc_d[CRC_W-1 -: IDX_W];

  always_comb begin
    crc_d  = crc_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load) begin
      crc_d  = '1;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      crc_d = step;
      if (fin) begin
        cnt_d  = '0;
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/daf_hash_table.sv
module daf_hash_table #(
  parameter int  WORD_W  = 32,
  parameter int  N_WORDS = 2,
  localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int TBL_W   = WORD_W * N_WORDS,
  localparam int IDX_W   = $clog2(TBL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              look_hit
);
  logic [TBL_W-1:0] tbl_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic we;
    assign we = wr_en && (sel == SEL_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl_q[w*WORD_W +: WORD_W] <= '0;
      else if (we) tbl_q[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  assign rd_data  = tbl_q[sel*WORD_W +: WORD_W];
  assign look_hit = tbl_q[look_idx];
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int  N_BYTES = DAF_N_BYTES,
  parameter int  WORD_W  = 32,
  parameter int  N_WORDS = 2,
  localparam int ADDR_W  = N_BYTES * DAF_BYTE_W,
  localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int IDX_W   = $clog2(WORD_W * N_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_valid,
  input  logic                  addr_start,
  input  logic [DAF_BYTE_W-1:0] addr_byte,
  input  logic [CFG_W-1:0]      cfg_mode,
  input  logic [ADDR_W-1:0]     station_addr,
  input  logic                  reg_wr,
  input  logic [SEL_W-1:0]      reg_sel,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  done,
  output logic                  accept,
  output logic                  hit_phys,
  output logic                  hit_bcast,
  output logic                  hit_mcast
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [ADDR_W-1:0] addr_q;
  logic              addr_full, crc_busy, crc_fin, look_hit;
  logic [IDX_W-1:0]  hash_idx;

  daf_addr_capture #(.N_BYTES(N_BYTES), .BYTE_W(DAF_BYTE_W)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .hold(crc_busy),
    .in_valid(addr_valid), .in_start(addr_start), .in_byte(addr_byte),
    .addr(addr_q), .full(addr_full)
  );

  daf_crc_serial #(.ADDR_W(ADDR_W), .CRC_W(DAF_CRC_W), .IDX_W(IDX_W),
                   .POLY(DAF_CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_core_n), .load(addr_full), .bits(addr_q),
    .busy(crc_busy), .fin(crc_fin), .idx(hash_idx)
  );

  daf_hash_table #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_tbl (
    .clk(clk), .rst_n(rst_core_n), .wr_en(reg_wr), .sel(reg_sel),
    .wr_data(reg_wdata), .rd_data(reg_rdata),
    .look_idx(hash_idx), .look_hit(look_hit)
  );

  logic is_mc, is_bc, is_ph;
  logic done_d, acc_d, ph_d, bc_d, mc_d;
  logic done_q, acc_q, ph_q, bc_q, mc_q;

  assign is_mc = addr_q[0];
  assign is_bc = &addr_q;
  assign is_ph = (addr_q == station_addr);

  always_comb begin
    done_d = crc_fin;
    ph_d   = crc_fin & is_ph & cfg_mode[CFG_PHYS];
    bc_d   = crc_fin & is_bc & cfg_mode[CFG_BCAST];
    mc_d   = crc_fin & is_mc & ~is_bc & cfg_mode[CFG_MCAST] & look_hit;
    acc_d  = crc_fin & (cfg_mode[CFG_ALL] | ph_d | bc_d | mc_d);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
      acc_q  <= 1'b0;
      ph_q   <= 1'b0;
      bc_q   <= 1'b0;
      mc_q   <= 1'b0;
    end else begin
      done_q <= done_d;
      acc_q  <= acc_d;
      ph_q   <= ph_d;
      bc_q   <= bc_d;
      mc_q   <= mc_d;
    end
  end

  assign done      = done_q;
  assign accept    = acc_q;
  assign hit_phys  = ph_q;
  assign hit_bcast = bc_q;
  assign hit_mcast = mc_q;
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
  parameter int WORD_W = 32,
  parameter int SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cfg_mode,
  input logic              reg_wr,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              done,
  input logic              accept,
  input logic              hit_phys,
  input logic              hit_bcast,
  input logic              hit_mcast
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_quiet_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !(accept | hit_phys | hit_bcast | hit_mcast));

  assert_hit_accepts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_phys | hit_bcast | hit_mcast) |-> accept);

  assert_accept_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_mode[0] && $past(cfg_mode[0])) |-> accept);

  assert_mcast_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mcast |-> $past(cfg_mode[2]));

  assert_bcast_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_bcast |-> (!hit_mcast && $past(cfg_mode[3])));

  assert_phys_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_phys |-> $past(cfg_mode[1]));

  assert_reg_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr) && (reg_sel == $past(reg_sel)))
      |-> (reg_rdata == $past(reg_wdata)));
endmodule

bind dest_addr_filter daf_checker #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .cfg_mode(cfg_mode),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .done(done), .accept(accept),
  .hit_phys(hit_phys), .hit_bcast(hit_bcast), .hit_mcast(hit_mcast)
);

// File: tb/dest_addr_filter_tb.sv
module dest_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_valid, addr_start;
  logic [7:0]  addr_byte;
  logic [3:0]  cfg;
  logic [47:0] st_addr;
  logic        reg_wr;
  logic [0:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        done, accept, hit_phys, hit_bcast, hit_mcast;

  logic [63:0] tbl;
  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  dest_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_start(addr_start),
    .addr_byte(addr_byte), .cfg_mode(cfg), .station_addr(st_addr),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .done(done), .accept(accept),
    .hit_phys(hit_phys), .hit_bcast(hit_bcast), .hit_mcast(hit_mcast)
  );

  function automatic logic [5:0] hidx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [3:0] expect_flags(input logic [47:0] a, input logic [3:0] c,
                                              input logic [63:0] t, input logic [47:0] s);
    logic bc, fph, fbc, fmc;
    bc  = &a;
    fph = (a == s) & c[1];
    fbc = bc & c[3];
    fmc = a[0] & ~bc & c[2] & t[hidx(a)];
    return {c[0] | fph | fbc | fmc, fph, fbc, fmc};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic put_byte(input logic st, input logic [7:0] b);
    addr_valid = 1'b1; addr_start = st; addr_byte = b;
    @(negedge clk);
    addr_valid = 1'b0; addr_start = 1'b0;
  endtask

  task automatic wr_word(input logic hi, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = hi; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    tbl[hi*32 +: 32] = d;
  endtask

  // send one address, wait for the verdict, check latency, flags and quiet after
  task automatic run_one(input logic [47:0] a, input bit junk, input string req);
    int lat;
    for (int i = 0; i < 6; i++) put_byte(i == 0, a[i*8 +: 8]);
    lat = 1;
    while (!done && lat < 200) begin
      if (junk) begin
        addr_valid = 1'b1; addr_start = 1'($urandom); addr_byte = 8'($urandom);
      end
      @(negedge clk);
      lat++;
    end
    addr_valid = 1'b0; addr_start = 1'b0;
    chk("R3 latency", 64'(lat), 64'd49);
    chk(req, {60'd0, accept, hit_phys, hit_bcast, hit_mcast},
        {60'd0, expect_flags(a, cfg, tbl, st_addr)});
    @(negedge clk);
    chk("R10 quiet after done", {60'd0, done, accept, hit_phys | hit_bcast, hit_mcast}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [47:0] a, mlo, mhi;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; addr_valid = 1'b0; addr_start = 1'b0; addr_byte = '0;
    cfg = 4'b0000; st_addr = 48'h5634_1200_AB02; reg_wr = 1'b0; reg_sel = 1'b0;
    reg_wdata = '0; tbl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", {60'd0, done, accept, hit_phys | hit_bcast, hit_mcast}, 64'd0);
    reg_sel = 1'b0; #1 chk("R1 low word", 64'(reg_rdata), 64'd0);
    reg_sel = 1'b1; #1 chk("R1 high word", 64'(reg_rdata), 64'd0);
    @(negedge clk);

    // R6 empty filter rejects multicast; R4/R5 single indexed bit accepts
    cfg = 4'b0100;
    mlo = '0; mhi = '0;
    for (int k = 0; k < 400; k++) begin
      a = {16'($urandom), 32'($urandom)};
      a[0] = 1'b1;
      if (hidx(a) < 6'd32 && mlo == '0) mlo = a;
      if (hidx(a) >= 6'd32 && mhi == '0) mhi = a;
    end
    run_one(mlo, 0, "R6 empty filter rejects");
    wr_word(0, 32'd1 << hidx(mlo));
    reg_sel = 1'b0; #1 chk("R5 readback low", 64'(reg_rdata), 64'(32'd1 << hidx(mlo)));
    run_one(mlo, 0, "R4 low word hit");
    chk("R6 accepted", 64'(accept | 1'b0), 64'd0); // outputs quiet again after done
    wr_word(0, 32'd0);
    wr_word(1, 32'd1 << (hidx(mhi) - 6'd32));
    reg_sel = 1'b1; #1 chk("R5 readback high", 64'(reg_rdata), 64'(32'd1 << (hidx(mhi) - 6'd32)));
    run_one(mhi, 0, "R5 high word hit");
    run_one(mlo, 0, "R5 low index misses");
    wr_word(1, ~(32'd1 << (hidx(mhi) - 6'd32)));
    wr_word(0, 32'hFFFF_FFFF);
    run_one(mhi, 0, "R4 neighbour bits miss");

    // R7 broadcast priority and enable
    wr_word(1, 32'hFFFF_FFFF);
    cfg = 4'b1100;
    run_one(48'hFFFF_FFFF_FFFF, 0, "R7 broadcast hit");
    cfg = 4'b0100;
    run_one(48'hFFFF_FFFF_FFFF, 0, "R7 broadcast not via hash");

    // R8 station match, enable and byte order
    cfg = 4'b0010;
    run_one(st_addr, 0, "R8 station hit");
    run_one({st_addr[7:0], st_addr[15:8], st_addr[23:16], st_addr[31:24],
             st_addr[39:32], st_addr[47:40]}, 0, "R8 byte order");
    cfg = 4'b0000;
    run_one(st_addr, 0, "R8 disabled");

    // R9 accept all
    cfg = 4'b0001;
    run_one(48'h0000_1234_5678, 0, "R9 accept all");

    // R2 stray bytes, restart mid-address
    cfg = 4'b0110;
    put_byte(0, 8'h11); put_byte(0, 8'h22);
    put_byte(1, 8'h33); put_byte(0, 8'h44); put_byte(0, 8'h55);
    run_one(st_addr, 0, "R2 restart");

    // R3 traffic during hashing is ignored
    run_one(st_addr, 1, "R3 ignore while hashing");
    run_one(mhi, 1, "R3 ignore while hashing mcast");

    // random mix
    for (int n = 0; n < 100; n++) begin
      int kind;
      if ($urandom % 8 == 0) begin
        wr_word(0, $urandom);
        wr_word(1, $urandom);
      end
      cfg = 4'($urandom);
      kind = $urandom % 6;
      a = {16'($urandom), 32'($urandom)};
      if (kind == 0) a = st_addr;
      else if (kind == 1) a = '1;
      else if (kind < 4) a[0] = 1'b1;
      run_one(a, n % 3 == 0, "R10 random verdict");
    end

    finish_run();
  end
endmodule